// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block turns one multi-register transfer instruction into a stream of simple micro-ops. The instruction is either a load of several registers or a store of several registers. Its operands are a 16-bit register mask, a base register number and five control bits:

- load or store,
- ascending or descending addresses,
- address adjustment before or after each access,
- base update,
- user-bank access.

The block emits one micro-op per accepted output transfer over a valid/ready pair. It takes a new instruction only when it is idle.

The stream always opens with a copy of the base register into a scratch register, written as an add-immediate of zero. One memory micro-op follows for every set bit in the mask, taken from the lowest index to the highest. Each memory micro-op addresses the scratch register plus or minus an immediate byte offset. When the base update is requested, a closing add or subtract of four bytes per transferred register is applied to the base register itself.

Register numbers 0 to 15 are the architectural registers, 16 to 31 are the user-bank views of those same registers, and 32 is the scratch register. A load of register 15 with user-bank access set becomes an exception-return load. The executing unit restores the status register from its saved copy when it performs that load.

Top module: `lsm_uop_seq`

## Requirements
- R1: The first micro-op after acceptance is ADDI (opcode 0), with destination 32, source equal to the base register number, and immediate 0.
- R2: After the copy, exactly one memory micro-op follows for each set bit of the mask, in ascending bit order. Its source is register 32.
- R3: When ascending, memory offsets start at 4 if pre-adjust is set and at 0 otherwise, and then rise by 4. When descending with N set bits, they start at 4N if pre-adjust is set and at 4N-4 otherwise, and then fall by 4. out_dec is 1 on memory micro-ops of a descending transfer and 0 on all other micro-ops.
- R4: A memory micro-op is LDR (opcode 2) for a load and STR (opcode 4) for a store. Its destination is the mask bit index i, or 16+i when user-bank access is set.
- R5: A load of bit 15 with user-bank access set uses LDR_RET (opcode 3) in place of LDR, with destination 31.
- R6: With base update requested, a final micro-op follows the memory micro-ops. It is ADDI when ascending and SUBI (opcode 1) when descending, with destination and source equal to the base register number and immediate 4N.
- R7: The sequence has 1+N micro-ops, plus one more with base update. out_last is 1 on the final micro-op only, so an empty mask without base update gives a single copy marked last.
- R8: in_ready is 1 only while idle. in_valid presented while busy is ignored and does not alter the running sequence.
- R9: While out_valid is 1 and out_ready is 0, out_valid and every micro-op field hold their values.
- R10: The first micro-op is valid in the cycle after acceptance. out_valid falls in the cycle after the last micro-op is taken.
- R11: During and right after reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle and able to accept |
| in_list | input | 16 | Register mask, bit i selects register i |
| in_base | input | 4 | Base register number |
| in_load | input | 1 | 1 = load, 0 = store |
| in_up | input | 1 | 1 = ascending addresses |
| in_pre | input | 1 | 1 = adjust address before access |
| in_wb | input | 1 | 1 = update base register at end |
| in_user | input | 1 | 1 = access user-bank registers |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Consumer takes micro-op |
| out_op | output | 3 | 0 ADDI, 1 SUBI, 2 LDR, 3 LDR_RET, 4 STR |
| out_rd | output | 6 | Destination or data register number |
| out_rs | output | 6 | Source or address-base register number |
| out_imm | output | 7 | Immediate or byte offset |
| out_dec | output | 1 | Memory address is source minus immediate |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
On every cycle, the assertions check:

- the copy micro-op that follows each acceptance,
- the scratch source of every memory micro-op,
- the destination of each exception-return load,
- that a subtracting update is always last,
- that out_dec appears only on memory micro-ops,
- output holding under back-pressure,
- the fall of out_valid after the last transfer.

The exact order of registers, the offset progression for each of the four addressing modes, the micro-op count, the user-bank remapping and the immunity to input offered while busy only show up when a whole sequence is compared against a model. The bench's directed and random scenarios cover those, with random back-pressure throughout.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [2:0] {
    UOP_ADDI    = 3'd0,
    UOP_SUBI    = 3'd1,
    UOP_LDR     = 3'd2,
    UOP_LDR_RET = 3'd3,
    UOP_STR     = 3'd4
  } uop_op_e;

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end

endmodule

// File: rtl/lsm_lowest_bit.sv
module lsm_lowest_bit #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  onehot,
  output logic [IW-1:0] idx
);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_sel
      if (g == 0) begin : g_first
        assign onehot[g] = vec[g];
      end else begin : g_rest
        assign onehot[g] = vec[g] & ~(|vec[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq
  import lsm_pkg::*;
#(
  parameter int LIST_W   = 16,
  parameter int REG_W    = 6,
  parameter int USER_OFS = 16,
  parameter int TMP_REG  = 32,
  parameter int PC_IDX   = 15,
  localparam int IDX_W   = $clog2(LIST_W),
  localparam int CNT_W   = $clog2(LIST_W + 1),
  localparam int IMM_W   = $clog2(4 * LIST_W + 5)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LIST_W-1:0] in_list,
  input  logic [IDX_W-1:0]  in_base,
  input  logic              in_load,
  input  logic              in_up,
  input  logic              in_pre,
  input  logic              in_wb,
  input  logic              in_user,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_op,
  output logic [REG_W-1:0]  out_rd,
  output logic [REG_W-1:0]  out_rs,
  output logic [IMM_W-1:0]  out_imm,
  output logic              out_dec,
  output logic              out_last
);

  // Latched instruction state
  logic [LIST_W-1:0] mask_q;
  logic [IDX_W-1:0]  base_q;
  logic              load_q, up_q, user_q, wb_pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IMM_W-1:0]  off_q;

  // Helpers
  logic [CNT_W-1:0]  in_cnt;
  logic [LIST_W-1:0] low_oh;
  logic [IDX_W-1:0]  low_idx;
  logic [LIST_W-1:0] mask_nxt;
  logic [IMM_W-1:0]  start_off;
  logic [IMM_W-1:0]  in_bytes;
  logic [REG_W-1:0]  mem_rd;
  uop_op_e           mem_op;
  logic              accept, fire;

  lsm_popcount #(.W(LIST_W)) u_cnt (
    .vec (in_list),
    .cnt (in_cnt)
  );

  lsm_lowest_bit #(.W(LIST_W)) u_low (
    .vec    (mask_q),
    .onehot (low_oh),
    .idx    (low_idx)
  );

  assign in_ready = ~out_valid;
  assign accept   = in_valid & ~out_valid;
  assign fire     = out_valid & out_ready;
  assign mask_nxt = mask_q & ~low_oh;
  assign in_bytes = IMM_W'({in_cnt, 2'b00});

  // Offset of the first memory micro-op for the four addressing modes
  always_comb begin
    if (in_up) start_off = in_pre ? IMM_W'(4) : '0;
    else       start_off = in_pre ? in_bytes : in_bytes - IMM_W'(4);
  end

  // Memory micro-op fields for the lowest remaining mask bit
  always_comb begin
    mem_rd = user_q ? REG_W'(USER_OFS) + REG_W'(low_idx) : REG_W'(low_idx);
    if (!load_q)                                    mem_op = UOP_STR;
    else if (user_q && (low_idx == IDX_W'(PC_IDX))) mem_op = UOP_LDR_RET;
    else                                            mem_op = UOP_LDR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_op    <= UOP_ADDI;
      out_rd    <= '0;
      out_rs    <= '0;
      out_imm   <= '0;
      out_dec   <= 1'b0;
      out_last  <= 1'b0;
      mask_q    <= '0;
      base_q    <= '0;
      load_q    <= 1'b0;
      up_q      <= 1'b0;
      user_q    <= 1'b0;
      wb_pend_q <= 1'b0;
      cnt_q     <= '0;
      off_q     <= '0;
    end else if (accept) begin
      mask_q    <= in_list;
      base_q    <= in_base;
      load_q    <= in_load;
      up_q      <= in_up;
      user_q    <= in_user;
      wb_pend_q <= in_wb;
      cnt_q     <= in_cnt;
      off_q     <= start_off;
      out_valid <= 1'b1;
      out_op    <= UOP_ADDI;
      out_rd    <= REG_W'(TMP_REG);
      out_rs    <= REG_W'(in_base);
      out_imm   <= '0;
      out_dec   <= 1'b0;
      out_last  <= (in_cnt == '0) && !in_wb;
    end else if (fire) begin
      if (out_last) begin
        out_valid <= 1'b0;
      end else if (|mask_q) begin
        out_op   <= mem_op;
        out_rd   <= mem_rd;
        out_rs   <= REG_W'(TMP_REG);
        out_imm  <= off_q;
        out_dec  <= ~up_q;
        out_last <= (mask_nxt == '0) && !wb_pend_q;
        mask_q   <= mask_nxt;
        off_q    <= up_q ? off_q + IMM_W'(4) : off_q - IMM_W'(4);
      end else begin
        out_op    <= up_q ? UOP_ADDI : UOP_SUBI;
        out_rd    <= REG_W'(base_q);
        out_rs    <= REG_W'(base_q);
        out_imm   <= IMM_W'({cnt_q, 2'b00});
        out_dec   <= 1'b0;
        out_last  <= 1'b1;
        wb_pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk #(
  parameter int REG_W    = 6,
  parameter int USER_OFS = 16,
  parameter int TMP_REG  = 32,
  parameter int PC_IDX   = 15,
  parameter int IDX_W    = 4,
  parameter int IMM_W    = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IDX_W-1:0] in_base,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2:0]       out_op,
  input logic [REG_W-1:0] out_rd,
  input logic [REG_W-1:0] out_rs,
  input logic [IMM_W-1:0] out_imm,
  input logic             out_dec,
  input logic             out_last
);

  logic is_mem;
  assign is_mem = (out_op == 3'd2) || (out_op == 3'd3) || (out_op == 3'd4);

  // R1
  copy_first_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_op == 3'd0 && out_rd == REG_W'(TMP_REG)
      && out_imm == '0 && out_rs == REG_W'($past(in_base)));

  // R2
  mem_src_tmp_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && is_mem |-> out_rs == REG_W'(TMP_REG));

  // R3
  dec_only_mem_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_dec |-> is_mem);

  // R5
  ret_dest_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_op == 3'd3 |-> out_rd == REG_W'(USER_OFS + PC_IDX));

  // R6
  sub_is_last_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_op == 3'd1 |-> out_last && out_rd == out_rs);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_rd)
      && $stable(out_rs) && $stable(out_imm) && $stable(out_dec) && $stable(out_last));

  // R10
  drop_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid);

endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(
  .REG_W(REG_W), .USER_OFS(USER_OFS), .TMP_REG(TMP_REG), .PC_IDX(PC_IDX),
  .IDX_W(IDX_W), .IMM_W(IMM_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_base(in_base),
  .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_rd(out_rd),
  .out_rs(out_rs), .out_imm(out_imm), .out_dec(out_dec), .out_last(out_last)
);

// File: tb/tb_lsm_uop_seq.sv
module tb_lsm_uop_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_list = '0;
  logic [3:0]  in_base = '0;
  logic        in_load = 1'b0, in_up = 1'b0, in_pre = 1'b0, in_wb = 1'b0, in_user = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_op;
  logic [5:0]  out_rd, out_rs;
  logic [6:0]  out_imm;
  logic        out_dec, out_last;

  int errors = 0;
  int checks = 0;

  int e_op[0:19], e_rd[0:19], e_rs[0:19], e_imm[0:19], e_dec[0:19], e_last[0:19];
  int e_n;

  always #4 clk = ~clk;

  lsm_uop_seq dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_list(in_list), .in_base(in_base), .in_load(in_load), .in_up(in_up),
    .in_pre(in_pre), .in_wb(in_wb), .in_user(in_user),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_rd(out_rd), .out_rs(out_rs), .out_imm(out_imm), .out_dec(out_dec),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Expected stream built from the requirements
  task automatic build(input logic [15:0] l, input int b, input bit ld, input bit up,
                       input bit pre, input bit wb, input bit usr);
    int n, off, k;
    n = 0;
    for (int i = 0; i < 16; i++) n += int'(l[i]);
    e_op[0] = 0; e_rd[0] = 32; e_rs[0] = b; e_imm[0] = 0; e_dec[0] = 0;  // R1
    k = 1;
    off = up ? (pre ? 4 : 0) : (pre ? 4*n : 4*n - 4);                     // R3
    for (int i = 0; i < 16; i++) begin
      if (l[i]) begin                                                     // R2
        e_op[k]  = !ld ? 4 : ((i == 15 && usr) ? 3 : 2);                  // R4 R5
        e_rd[k]  = usr ? 16 + i : i;
        e_rs[k]  = 32;
        e_imm[k] = off;
        e_dec[k] = up ? 0 : 1;
        off += up ? 4 : -4;
        k++;
      end
    end
    if (wb) begin                                                         // R6
      e_op[k] = up ? 0 : 1; e_rd[k] = b; e_rs[k] = b; e_imm[k] = 4*n; e_dec[k] = 0;
      k++;
    end
    for (int i = 0; i < 20; i++) e_last[i] = (i == k - 1) ? 1 : 0;        // R7
    e_n = k;
  endtask

  task automatic run(input logic [15:0] l, input int b, input bit ld, input bit up,
                     input bit pre, input bit wb, input bit usr, input bit poke);
    int k, cyc;
    bit done, held, rdy, first;
    logic [2:0] h_op; logic [5:0] h_rd, h_rs; logic [6:0] h_imm; logic h_dec, h_last;
    build(l, b, ld, up, pre, wb, usr);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_list = l; in_base = 4'(b);
    in_load = ld; in_up = up; in_pre = pre; in_wb = wb; in_user = usr;
    k = 0; cyc = 0; done = 0; held = 0; first = 1;
    h_op = '0; h_rd = '0; h_rs = '0; h_imm = '0; h_dec = 0; h_last = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (poke) begin
        // R8: garbage offered while busy
        in_valid = 1'b1; in_list = 16'(~l); in_base = 4'(~b); in_load = !ld; in_up = !up;
        in_wb = !wb; in_user = !usr;
      end else in_valid = 1'b0;
      if (first) begin
        chk(out_valid === 1'b1, "R10 valid after accept", int'(out_valid), 1);
        chk(in_ready === 1'b0, "R8 busy after accept", int'(in_ready), 0);
        first = 0;
      end
      if (out_valid) begin
        if (held) begin
          chk(out_op == h_op && out_rd == h_rd && out_rs == h_rs && out_imm == h_imm
              && out_dec == h_dec && out_last == h_last, "R9 hold", int'(out_imm), int'(h_imm));
        end
        rdy = ($urandom % 4) != 0;
        out_ready = rdy;
        if (rdy) begin
          if (k < e_n) begin
            chk(int'(out_op) == e_op[k], "R2 R4 R5 R6 opcode", int'(out_op), e_op[k]);
            chk(int'(out_rd) == e_rd[k], "R1 R4 R6 dest", int'(out_rd), e_rd[k]);
            chk(int'(out_rs) == e_rs[k], "R1 R2 source", int'(out_rs), e_rs[k]);
            chk(int'(out_imm) == (e_imm[k] & 127), "R3 R6 imm", int'(out_imm), e_imm[k]);
            chk(int'(out_dec) == e_dec[k], "R3 dec", int'(out_dec), e_dec[k]);
            chk(int'(out_last) == e_last[k], "R7 last", int'(out_last), e_last[k]);
          end else begin
            chk(1'b0, "R7 extra micro-op", k, e_n);
          end
          if (out_last) done = 1;
          k++;
          held = 0;
        end else begin
          held = 1;
          h_op = out_op; h_rd = out_rd; h_rs = out_rs; h_imm = out_imm;
          h_dec = out_dec; h_last = out_last;
        end
      end else out_ready = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    chk(k == e_n, "R7 count", k, e_n);
    chk(out_valid === 1'b0, "R10 valid drops", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R8 idle again", int'(in_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R11
    chk(out_valid === 1'b0, "R11 valid in reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R11 ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11 valid after reset", int'(out_valid), 0);
    // Directed corners
    run(16'h0000, 3, 1, 1, 0, 0, 0, 0);   // R7 empty, copy only
    run(16'h0000, 5, 0, 0, 1, 1, 0, 0);   // R6 empty with update
    run(16'hFFFF, 13, 1, 1, 1, 1, 1, 0);  // R5 full, user, return load
    run(16'h8000, 2, 1, 1, 0, 0, 1, 0);   // R5 single return load
    run(16'h8000, 2, 0, 1, 0, 0, 1, 0);   // R4 store of 15 stays STR
    run(16'h8001, 4, 1, 0, 0, 1, 0, 0);   // R4 load 15 without user
    run(16'h0A52, 1, 0, 0, 0, 1, 0, 0);   // R3 descending post
    run(16'h0A52, 1, 0, 0, 1, 1, 0, 0);   // R3 descending pre
    run(16'h0A52, 6, 1, 1, 1, 0, 1, 1);   // R8 input while busy
    run(16'hFFFF, 0, 0, 0, 1, 1, 1, 1);   // R3 R6 full descending
    // Random
    for (int t = 0; t < 60; t++) begin
      run(16'($urandom), int'($urandom % 16), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 1'(($urandom % 3) == 0));
    end
    summary();
  end

endmodule